// File: doc/BRIEF.md
# Engine Enable and Power-Clamp Override Register Block

This block is a three-word register file on a simple 32-bit read/write bus. It sits on the target side of the sequence that brings a power-gated graphics engine out of its boot state. Software performs read-modify-write steps on it. One register holds the engine enables, and each cleared enable bit holds that engine in reset. A second register can force the isolation-clamp enables of power-switched domains. A third register can override the power-gate state that a boot strap selects.

The bus side has no handshake. A write is taken on the clock edge that samples the write strobe. Read data is combinational and is valid in the same cycle as the read strobe. The two low address bits are ignored, so every access is a full word. The outputs are a registered graphics-engine reset, the block-level gating controller enable, one clamp-enable per clamp domain and the resolved power-gate state. The inputs are the internal clamp-enable requests and the boot power-gate strap.

Top module: `pgctl_regs`

## Requirements
- R1: After reset, every register reads 0x00000000. `gfx_rst_o` is 1, `gating_en_o` is 0, `clamp_en_o` follows `clamp_req_i`, and `pg_active_o` follows `boot_pg_i`.
- R2: The engine register is at word address 0x200, with address bits [1:0] ignored. Bit 12 enables the graphics engine and bit 27 enables the block-level gating controllers. A write lands on the clock edge that samples `wr_en`, and the register reads back in the next cycle.
- R3: `gfx_rst_o` is 1 exactly while bit 12 of the engine register is 0. It comes from a flop, so it changes only on the edge that captures a write to that register.
- R4: `gating_en_o` equals bit 27 of the engine register.
- R5: The clamp register is at 0x10A78C. Bit 0 is the clamp mask and bit 1 is the clamp value. While the mask is 1, `clamp_en_o` equals the clamp value.
- R6: While the clamp mask is 0, `clamp_en_o` follows `clamp_req_i` combinationally.
- R7: The power-gate control register is at 0x20004. Bit 30 is the override enable and bit 31 is the override value (1 = gated on, 0 = off). While the override is enabled, `pg_active_o` equals the override value.
- R8: While the override enable is 0, `pg_active_o` follows `boot_pg_i` combinationally.
- R9: Unimplemented bits of each register read as 0, and writing them changes no output.
- R10: A read from an unmapped address returns 0. A write to an unmapped address changes no register and no output.
- R11: `rd_data` is 0 whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 32 | Byte address; bits [1:0] ignored |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, same cycle as `rd_en` |
| clamp_req_i | input | NUM_CLAMPS | Internal clamp-enable requests |
| boot_pg_i | input | 1 | Boot power-gate strap |
| gfx_rst_o | output | 1 | Graphics engine reset, active high |
| gating_en_o | output | 1 | Block-level power/clock gating controller enable |
| clamp_en_o | output | NUM_CLAMPS | Resolved clamp enables |
| pg_active_o | output | 1 | Resolved power-gate state |

## Verification
A wrong bit in the engine register shows up on `gfx_rst_o` or `gating_en_o` one edge after the write. A wrong readback shows in the same cycle as the following read. A clamp or override flop that holds the wrong value is visible on `clamp_en_o` or `pg_active_o` as soon as the mask or override is set. While the mask or override is clear, the same fault is hidden, and only readback or toggling `clamp_req_i` / `boot_pg_i` exposes it. A decode error at an unmapped or aliased address appears only as a nonzero read or as a disturbed output after a stray write, so both are probed explicitly.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;

   localparam int unsigned DATA_W      = 32;
   // Bit positions that software decodes; they are fixed.
   localparam int unsigned GFX_EN_BIT  = 12;
   localparam int unsigned GATE_EN_BIT = 27;
   localparam int unsigned OVR_EN_BIT  = 30;
   localparam int unsigned OVR_VAL_BIT = 31;

   typedef enum logic [1:0] {
      REG_NONE   = 2'd0,
      REG_ENGINE = 2'd1,
      REG_CLAMP  = 2'd2,
      REG_PGCTL  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/pgctl_decode.sv
module pgctl_decode
   import pgctl_pkg::*;
#(
   parameter int unsigned          ADDR_W      = 32,
   parameter logic [ADDR_W-1:0]    ENGINE_ADDR = 'h0000_0200,
   parameter logic [ADDR_W-1:0]    CLAMP_ADDR  = 'h0010_A78C,
   parameter logic [ADDR_W-1:0]    PGCTL_ADDR  = 'h0002_0004
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);

   localparam int unsigned WORD_W = ADDR_W - 2;

   // Elaboration checks on the address map.
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("pgctl_decode: ADDR_W too small");
   end
   if (ENGINE_ADDR[1:0] != 2'b00 || CLAMP_ADDR[1:0] != 2'b00 ||
       PGCTL_ADDR[1:0] != 2'b00) begin : g_unaligned
      $error("pgctl_decode: register addresses must be word aligned");
   end
   if (ENGINE_ADDR == CLAMP_ADDR || ENGINE_ADDR == PGCTL_ADDR ||
       CLAMP_ADDR == PGCTL_ADDR) begin : g_overlap
      $error("pgctl_decode: register addresses must be distinct");
   end

   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];

   always_comb begin
      if (word == ENGINE_ADDR[ADDR_W-1:2])      sel = REG_ENGINE;
      else if (word == CLAMP_ADDR[ADDR_W-1:2])  sel = REG_CLAMP;
      else if (word == PGCTL_ADDR[ADDR_W-1:2])  sel = REG_PGCTL;
      else                                      sel = REG_NONE;
   end

   logic unused_low_addr;
   assign unused_low_addr = ^addr[1:0];

endmodule

// File: rtl/pgctl_engine_en.sv
module pgctl_engine_en
   import pgctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              gfx_en_i,
   input  logic              gate_en_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              gfx_rst_o,
   output logic              gating_en_o
);

   // The reset flop stores the inverted enable, so the output comes
   // straight from a flop.
   logic gfx_rst_q;
   logic gate_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gfx_rst_q <= 1'b1;
         gate_en_q <= 1'b0;
      end else if (wr_stb) begin
         gfx_rst_q <= ~gfx_en_i;
         gate_en_q <= gate_en_i;
      end
   end

   assign gfx_rst_o   = gfx_rst_q;
   assign gating_en_o = gate_en_q;

   always_comb begin
      rdata_o              = '0;
      rdata_o[GFX_EN_BIT]  = ~gfx_rst_q;
      rdata_o[GATE_EN_BIT] = gate_en_q;
   end

   assert_rst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb |=> $stable(gfx_rst_o));
   assert_rst_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && gfx_en_i) |=> !gfx_rst_o);
   assert_rst_apply_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !gfx_en_i) |=> gfx_rst_o);
   assert_gate_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> (gating_en_o == $past(gate_en_i)));

endmodule

// File: rtl/pgctl_clamp.sv
module pgctl_clamp
   import pgctl_pkg::*;
#(
   parameter int unsigned NUM_CLAMPS = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic [2*NUM_CLAMPS-1:0] wr_fields_i,
   input  logic [NUM_CLAMPS-1:0]   clamp_req_i,
   output logic [DATA_W-1:0]       rdata_o,
   output logic [NUM_CLAMPS-1:0]   clamp_en_o
);

   localparam int unsigned FIELD_W = 2 * NUM_CLAMPS;

   if (NUM_CLAMPS < 1 || FIELD_W > DATA_W) begin : g_bad_clamps
      $error("pgctl_clamp: NUM_CLAMPS must be 1..16");
   end

   logic [FIELD_W-1:0] fields;

   // Each domain k has its mask at bit 2k and its value at bit 2k+1.
   for (genvar k = 0; k < NUM_CLAMPS; k++) begin : g_dom
      logic mask_q;
      logic val_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= 1'b0;
            val_q  <= 1'b0;
         end else if (wr_stb) begin
            mask_q <= wr_fields_i[2*k];
            val_q  <= wr_fields_i[2*k+1];
         end
      end

      assign clamp_en_o[k]   = mask_q ? val_q : clamp_req_i[k];
      assign fields[2*k]     = mask_q;
      assign fields[2*k+1]   = val_q;

      assert_clamp_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && wr_fields_i[2*k]) |=> (clamp_en_o[k] == $past(wr_fields_i[2*k+1])));
      assert_clamp_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_stb && !wr_fields_i[2*k]) |=> (clamp_en_o[k] == clamp_req_i[k]));
   end

   assign rdata_o = DATA_W'(fields);

endmodule

// File: rtl/pgctl_pg_override.sv
module pgctl_pg_override
   import pgctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              ovr_en_i,
   input  logic              ovr_val_i,
   input  logic              boot_pg_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              pg_active_o
);

   logic ovr_en_q;
   logic ovr_val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_en_q  <= 1'b0;
         ovr_val_q <= 1'b0;
      end else if (wr_stb) begin
         ovr_en_q  <= ovr_en_i;
         ovr_val_q <= ovr_val_i;
      end
   end

   assign pg_active_o = ovr_en_q ? ovr_val_q : boot_pg_i;

   always_comb begin
      rdata_o              = '0;
      rdata_o[OVR_EN_BIT]  = ovr_en_q;
      rdata_o[OVR_VAL_BIT] = ovr_val_q;
   end

   assert_ovr_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && ovr_en_i) |=> (pg_active_o == $past(ovr_val_i)));
   assert_ovr_strap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !ovr_en_i) |=> (pg_active_o == boot_pg_i));

endmodule

// File: rtl/pgctl_regs.sv
module pgctl_regs
   import pgctl_pkg::*;
#(
   parameter int unsigned          ADDR_W      = 32,
   parameter int unsigned          NUM_CLAMPS  = 1,
   parameter logic [ADDR_W-1:0]    ENGINE_ADDR = 'h0000_0200,
   parameter logic [ADDR_W-1:0]    CLAMP_ADDR  = 'h0010_A78C,
   parameter logic [ADDR_W-1:0]    PGCTL_ADDR  = 'h0002_0004
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  rd_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [DATA_W-1:0]     wr_data,
   output logic [DATA_W-1:0]     rd_data,
   input  logic [NUM_CLAMPS-1:0] clamp_req_i,
   input  logic                  boot_pg_i,
   output logic                  gfx_rst_o,
   output logic                  gating_en_o,
   output logic [NUM_CLAMPS-1:0] clamp_en_o,
   output logic                  pg_active_o
);

   localparam int unsigned FIELD_W = 2 * NUM_CLAMPS;

   reg_sel_e          sel;
   logic              wr_engine, wr_clamp, wr_pgctl;
   logic [DATA_W-1:0] engine_rdata, clamp_rdata, pgctl_rdata;

   pgctl_decode #(
      .ADDR_W      (ADDR_W),
      .ENGINE_ADDR (ENGINE_ADDR),
      .CLAMP_ADDR  (CLAMP_ADDR),
      .PGCTL_ADDR  (PGCTL_ADDR)
   ) u_decode (
      .addr (addr),
      .sel  (sel)
   );

   assign wr_engine = wr_en && (sel == REG_ENGINE);
   assign wr_clamp  = wr_en && (sel == REG_CLAMP);
   assign wr_pgctl  = wr_en && (sel == REG_PGCTL);

   pgctl_engine_en u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_engine),
      .gfx_en_i    (wr_data[GFX_EN_BIT]),
      .gate_en_i   (wr_data[GATE_EN_BIT]),
      .rdata_o     (engine_rdata),
      .gfx_rst_o   (gfx_rst_o),
      .gating_en_o (gating_en_o)
   );

   pgctl_clamp #(
      .NUM_CLAMPS (NUM_CLAMPS)
   ) u_clamp (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_clamp),
      .wr_fields_i (wr_data[FIELD_W-1:0]),
      .clamp_req_i (clamp_req_i),
      .rdata_o     (clamp_rdata),
      .clamp_en_o  (clamp_en_o)
   );

   pgctl_pg_override u_override (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_pgctl),
      .ovr_en_i    (wr_data[OVR_EN_BIT]),
      .ovr_val_i   (wr_data[OVR_VAL_BIT]),
      .boot_pg_i   (boot_pg_i),
      .rdata_o     (pgctl_rdata),
      .pg_active_o (pg_active_o)
   );

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         unique case (sel)
            REG_ENGINE: rd_data = engine_rdata;
            REG_CLAMP:  rd_data = clamp_rdata;
            REG_PGCTL:  rd_data = pgctl_rdata;
            default:    rd_data = '0;
         endcase
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));
   assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == REG_NONE) |-> (rd_data == '0));
   assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == REG_NONE) |=> ($stable(engine_rdata) && $stable(clamp_rdata)
                                      && $stable(pgctl_rdata)));

endmodule

// File: tb/pgctl_regs_tb.sv
module pgctl_regs_tb;

   localparam logic [31:0] A_ENG = 32'h0000_0200;
   localparam logic [31:0] A_CLP = 32'h0010_A78C;
   localparam logic [31:0] A_PGC = 32'h0002_0004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [0:0]  clamp_req_i = 1'b0;
   logic        boot_pg_i = 1'b0;
   logic        gfx_rst_o, gating_en_o, pg_active_o;
   logic [0:0]  clamp_en_o;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   pgctl_regs u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wr_data     (wr_data),
      .rd_data     (rd_data),
      .clamp_req_i (clamp_req_i),
      .boot_pg_i   (boot_pg_i),
      .gfx_rst_o   (gfx_rst_o),
      .gating_en_o (gating_en_o),
      .clamp_en_o  (clamp_en_o),
      .pg_active_o (pg_active_o)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #2 d = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 gfx_rst_o", 32'(gfx_rst_o), 32'd1);
      chk("R1 gating_en_o", 32'(gating_en_o), 32'd0);
      bus_rd(A_ENG, d); chk("R1 engine reg", d, 32'h0);
      bus_rd(A_CLP, d); chk("R1 clamp reg", d, 32'h0);
      bus_rd(A_PGC, d); chk("R1 pgctl reg", d, 32'h0);
      @(negedge clk); clamp_req_i = 1'b1; boot_pg_i = 1'b1; #1;
      chk("R1 clamp follows req", 32'(clamp_en_o), 32'd1);
      chk("R1 pg follows strap", 32'(pg_active_o), 32'd1);
      clamp_req_i = 1'b0; boot_pg_i = 1'b0;
      @(negedge clk); addr = A_ENG; #1;
      chk("R11 rd_data idle", rd_data, 32'h0);
   endtask

   task automatic t_engine();
      logic [31:0] d;
      // enable graphics only
      bus_wr(A_ENG, 32'h0000_1000);
      chk("R3 reset released", 32'(gfx_rst_o), 32'd0);
      chk("R4 gating stays off", 32'(gating_en_o), 32'd0);
      bus_rd(A_ENG, d); chk("R2 readback gfx", d, 32'h0000_1000);
      // set gating bit while keeping graphics enabled; reset must not move
      @(negedge clk);
      addr = A_ENG; wr_data = 32'h0800_1000; wr_en = 1'b1;
      #1 chk("R3 no change before edge", 32'(gfx_rst_o), 32'd0);
      @(negedge clk); wr_en = 1'b0;
      chk("R4 gating on", 32'(gating_en_o), 32'd1);
      chk("R3 reset stays released", 32'(gfx_rst_o), 32'd0);
      // byte-agnostic alias address
      bus_rd(A_ENG + 32'd3, d); chk("R2 low addr bits ignored", d, 32'h0800_1000);
      // disable graphics via aliased address
      bus_wr(A_ENG + 32'd1, 32'h0800_0000);
      chk("R3 reset reasserted", 32'(gfx_rst_o), 32'd1);
      // unimplemented bits
      bus_wr(A_ENG, 32'hFFFF_FFFF);
      bus_rd(A_ENG, d); chk("R9 engine unimplemented bits", d, 32'h0800_1000);
      bus_wr(A_ENG, 32'hF7FF_EFFF);
      chk("R9 reserved-only write reset", 32'(gfx_rst_o), 32'd1);
      chk("R9 reserved-only write gating", 32'(gating_en_o), 32'd0);
   endtask

   task automatic t_clamp();
      logic [31:0] d;
      bus_wr(A_CLP, 32'h0000_0003);
      @(negedge clk); clamp_req_i = 1'b0; #1;
      chk("R5 forced to 1", 32'(clamp_en_o), 32'd1);
      bus_wr(A_CLP, 32'h0000_0001);
      @(negedge clk); clamp_req_i = 1'b1; #1;
      chk("R5 forced to 0", 32'(clamp_en_o), 32'd0);
      bus_wr(A_CLP, 32'h0000_0002);
      @(negedge clk); clamp_req_i = 1'b0; #1;
      chk("R6 mask off follows req 0", 32'(clamp_en_o), 32'd0);
      clamp_req_i = 1'b1; #1;
      chk("R6 mask off follows req 1", 32'(clamp_en_o), 32'd1);
      bus_wr(A_CLP, 32'hFFFF_FFFF);
      bus_rd(A_CLP, d); chk("R9 clamp unimplemented bits", d, 32'h0000_0003);
      bus_wr(A_CLP, 32'h0000_0000);
      clamp_req_i = 1'b0;
   endtask

   task automatic t_override();
      logic [31:0] d;
      bus_wr(A_PGC, 32'h4000_0000);
      @(negedge clk); boot_pg_i = 1'b1; #1;
      chk("R7 override off value", 32'(pg_active_o), 32'd0);
      bus_wr(A_PGC, 32'hC000_0000);
      @(negedge clk); boot_pg_i = 1'b0; #1;
      chk("R7 override on value", 32'(pg_active_o), 32'd1);
      bus_wr(A_PGC, 32'h8000_0000);
      @(negedge clk); boot_pg_i = 1'b0; #1;
      chk("R8 strap 0", 32'(pg_active_o), 32'd0);
      boot_pg_i = 1'b1; #1;
      chk("R8 strap 1", 32'(pg_active_o), 32'd1);
      bus_wr(A_PGC, 32'hFFFF_FFFF);
      bus_rd(A_PGC, d); chk("R9 pgctl unimplemented bits", d, 32'hC000_0000);
      bus_wr(A_PGC, 32'h0000_0000);
      boot_pg_i = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      bus_wr(A_ENG, 32'h0000_1000);
      bus_wr(A_CLP, 32'h0000_0001);
      bus_wr(A_PGC, 32'h4000_0000);
      bus_wr(32'h0000_0204, 32'hFFFF_FFFF);
      bus_wr(32'h0002_0000, 32'hFFFF_FFFF);
      bus_wr(32'h0010_A788, 32'hFFFF_FFFF);
      bus_rd(32'h0000_0204, d); chk("R10 unmapped read", d, 32'h0);
      bus_rd(32'h0000_0000, d); chk("R10 unmapped read zero addr", d, 32'h0);
      chk("R10 gfx reset untouched", 32'(gfx_rst_o), 32'd0);
      chk("R10 gating untouched", 32'(gating_en_o), 32'd0);
      chk("R10 clamp untouched", 32'(clamp_en_o), 32'd0);
      chk("R10 pg untouched", 32'(pg_active_o), 32'd0);
      bus_rd(A_ENG, d); chk("R10 engine reg intact", d, 32'h0000_1000);
      bus_rd(A_CLP, d); chk("R10 clamp reg intact", d, 32'h0000_0001);
      bus_rd(A_PGC, d); chk("R10 pgctl reg intact", d, 32'h4000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_engine();
      t_clamp();
      t_override();
      t_unmapped();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule